// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when the processor core stops being clocked and when it is clocked again. It also drives the clock gates and power-down controls that go with each mode. A wait-for-interrupt strobe from the core asks for a low-power mode. Two control bits pick which mode is used. The first is a deep-sleep select bit. The second is a deep power-down enable bit, and when it is set the request is left alone. A vector of enabled pending interrupts, passed through a two-flop synchroniser, brings the core back. An asynchronous reset also brings it back.

The block holds three configuration registers:
- a run-time analog power-down mask,
- a sleep-time analog power-down mask,
- a per-peripheral bus-clock enable mask.

They are written through a small select/data port. In ordinary sleep only the core clock stops, and the analog blocks keep their run-time settings. In deep sleep every analog block is forced down except four:
- the brown-out detector and the watchdog oscillator, which follow the sleep-time mask;
- the real-time clock and its oscillator, which follow the run-time mask.

Top module: `lp_mode_seq`

## Requirements
- R1: With `mode` encoded 0 = active, 1 = sleep, 2 = deep sleep, a `wfi` strobe in active mode enters sleep (mode 1, `core_clk_en` low) at the next clock edge. This happens when `dpd_en` = 0, `deep_sel` = 0 and no synchronised interrupt is pending.
- R2: Under the same conditions but with `deep_sel` = 1, the strobe enters deep sleep (mode 2, `core_clk_en` low) at the next edge.
- R3: A `wfi` strobe while `dpd_en` = 1 is ignored. The mode stays 0 and `core_clk_en` stays high.
- R4: If the synchronised interrupt level is already nonzero when `wfi` arrives, the block stays in active mode.
- R5: `irq_pend` passes through two synchronising flops. A level applied before clock edge k is seen after edge k+1. A sleeping or deep-sleeping block returns to mode 0 with `core_clk_en` high at edge k+2.
- R6: In active and sleep modes, `analog_pd` equals the run-time mask and `periph_clk_en` equals the clock-enable mask. Peripherals keep their clocks during both sleep modes.
- R7: In deep sleep, every `analog_pd` bit is 1 except four. Bits 0 (brown-out detector) and 1 (watchdog oscillator) take the sleep-time mask. Bits 2 (real-time-clock oscillator) and 3 (real-time clock) take the run-time mask.
- R8: After a wake by interrupt, `analog_pd` returns to the run-time mask.
- R9: Reset, including reset taken while in sleep, gives mode 0 and `core_clk_en` = 1. It also restores the defaults: run-time mask 8'hF0, sleep-time mask 8'h03 and clock-enable mask 8'h01.
- R10: A `cfg_we` pulse writes `cfg_wdata` into the register picked by `cfg_sel` (0 = run-time mask, 1 = sleep-time mask, 2 = clock-enable mask), and the new value shows at the outputs from the next cycle. A write with `cfg_sel` = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, kept running in all modes |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi | input | 1 | Wait-for-interrupt strobe from the core |
| deep_sel | input | 1 | Selects deep sleep instead of sleep |
| dpd_en | input | 1 | Deep power-down enable; blocks entry when set |
| irq_pend | input | NUM_IRQ | Enabled pending interrupts, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | CFG_W | Configuration write data |
| mode | output | 2 | Current power mode |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock gate enables |
| analog_pd | output | NUM_ANALOG | Per-analog-block power-down controls |

## Verification
The bench exercises mode entry under these input patterns:
- a bare strobe with deep select low, then with it high;
- a strobe with power-down enable set;
- a strobe while an interrupt is already held.

Together these separate the sleep, deep-sleep, ignore and no-entry paths. Wakes come from single-cycle interrupt pulses on different lines. This exposes the two-cycle synchroniser delay and confirms the run-time mask comes back. Deep sleep runs twice, with the run-time real-time-clock bit set and then cleared, to show which mask each kept bit follows. A reset taken mid-sleep and a write to the unused select finish the run.

// File: rtl/lp_mode_seq.sv
module lp_mode_seq #(
  parameter int NUM_IRQ    = 8,
  parameter int NUM_PERIPH = 8,
  parameter int NUM_ANALOG = 8,
  parameter int BOD_BIT    = 0,
  parameter int WDOSC_BIT  = 1,
  parameter int RTCOSC_BIT = 2,
  parameter int RTC_BIT    = 3,
  parameter logic [NUM_ANALOG-1:0] RUN_PD_INIT   = 8'hF0,
  parameter logic [NUM_ANALOG-1:0] SLEEP_PD_INIT = 8'h03,
  parameter logic [NUM_PERIPH-1:0] CLKEN_INIT    = 8'h01,
  localparam int CFG_W = (NUM_ANALOG > NUM_PERIPH) ? NUM_ANALOG : NUM_PERIPH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wfi,
  input  logic                  deep_sel,
  input  logic                  dpd_en,
  input  logic [NUM_IRQ-1:0]    irq_pend,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_sel,
  input  logic [CFG_W-1:0]      cfg_wdata,
  output logic [1:0]            mode,
  output logic                  core_clk_en,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic [NUM_ANALOG-1:0] analog_pd
);

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'd0,
    MODE_SLEEP  = 2'd1,
    MODE_DEEP   = 2'd2
  } mode_t;

  mode_t mode_q, mode_d;
  logic [NUM_IRQ-1:0]    irq_s1, irq_s2;
  logic [NUM_ANALOG-1:0] run_pd_q, sleep_pd_q, deep_pd;
  logic [NUM_PERIPH-1:0] clken_q;
  logic                  wake;

  // Two-flop synchroniser on the interrupt level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_s1 <= '0;
      irq_s2 <= '0;
    end else begin
      irq_s1 <= irq_pend;
      irq_s2 <= irq_s1;
    end
  end

  assign wake = |irq_s2;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_ACTIVE:
        if (wfi && !dpd_en && !wake)
          mode_d = deep_sel ? MODE_DEEP : MODE_SLEEP;
      MODE_SLEEP, MODE_DEEP:
        if (wake) mode_d = MODE_ACTIVE;
      default: mode_d = MODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_ACTIVE;
    else        mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_pd_q   <= RUN_PD_INIT;
      sleep_pd_q <= SLEEP_PD_INIT;
      clken_q    <= CLKEN_INIT;
    end else if (cfg_we) begin
      unique case (cfg_sel)
        2'd0:    run_pd_q   <= cfg_wdata[NUM_ANALOG-1:0];
        2'd1:    sleep_pd_q <= cfg_wdata[NUM_ANALOG-1:0];
        2'd2:    clken_q    <= cfg_wdata[NUM_PERIPH-1:0];
        default: ;
      endcase
    end
  end

  // Deep-sleep mask: everything down except the kept blocks
  always_comb begin
    deep_pd             = '1;
    deep_pd[BOD_BIT]    = sleep_pd_q[BOD_BIT];
    deep_pd[WDOSC_BIT]  = sleep_pd_q[WDOSC_BIT];
    deep_pd[RTCOSC_BIT] = run_pd_q[RTCOSC_BIT];
    deep_pd[RTC_BIT]    = run_pd_q[RTC_BIT];
  end

  assign mode          = mode_q;
  assign core_clk_en   = (mode_q == MODE_ACTIVE);
  assign periph_clk_en = clken_q;
  assign analog_pd     = (mode_q == MODE_DEEP) ? deep_pd : run_pd_q;

  assert_sleep_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ACTIVE && wfi && !dpd_en && !deep_sel && !wake)
      |=> (mode == 2'd1 && !core_clk_en));

  assert_deep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ACTIVE && wfi && !dpd_en && deep_sel && !wake)
      |=> (mode == 2'd2 && !core_clk_en));

  assert_dpd_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ACTIVE && wfi && dpd_en) |=> core_clk_en);

  assert_pending_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ACTIVE && wake) |=> core_clk_en);

  assert_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_ACTIVE && wake) |=> (core_clk_en && mode == 2'd0));

  assert_sleep_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SLEEP && $past(mode_q) == MODE_ACTIVE && !$past(cfg_we))
      |-> ($stable(analog_pd) && $stable(periph_clk_en)));

  assert_deep_pd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DEEP) |-> ($countones(analog_pd) >= NUM_ANALOG - 4));

  assert_wake_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ACTIVE && $past(mode_q) != MODE_ACTIVE) |-> (analog_pd == run_pd_q));

  assert_cfg_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd2) |=> (periph_clk_en == $past(cfg_wdata[NUM_PERIPH-1:0])));

endmodule

// File: tb/tb_lp_mode_seq.sv
module tb_lp_mode_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wfi = 1'b0, deep_sel = 1'b0, dpd_en = 1'b0, cfg_we = 1'b0;
  logic [7:0] irq_pend = '0, cfg_wdata = '0;
  logic [1:0] cfg_sel = '0;
  logic [1:0] mode;
  logic       core_clk_en;
  logic [7:0] periph_clk_en, analog_pd;

  lp_mode_seq dut (
    .clk(clk), .rst_n(rst_n), .wfi(wfi), .deep_sel(deep_sel), .dpd_en(dpd_en),
    .irq_pend(irq_pend), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mode(mode), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .analog_pd(analog_pd));

  always #10 clk = ~clk;

  int    errors = 0, checks = 0;
  bit    done = 1'b0;
  string cur_req = "R9";

  // Behavioural reference model
  int         m_mode;
  logic [7:0] m_run, m_sleep, m_clk, m_s1, m_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_run = 8'hF0; m_sleep = 8'h03; m_clk = 8'h01;
      m_s1 = '0; m_s2 = '0;
    end else begin
      if (m_mode == 0) begin
        if (wfi && !dpd_en && m_s2 == 0) m_mode = deep_sel ? 2 : 1;
      end else if (m_s2 != 0) m_mode = 0;
      m_s2 = m_s1;
      m_s1 = irq_pend;
      if (cfg_we) begin
        if (cfg_sel == 0) m_run = cfg_wdata;
        else if (cfg_sel == 1) m_sleep = cfg_wdata;
        else if (cfg_sel == 2) m_clk = cfg_wdata;
      end
    end
  end

  function automatic logic [7:0] exp_pd();
    logic [7:0] v;
    if (m_mode != 2) return m_run;
    v = 8'hFF;
    v[0] = m_sleep[0]; v[1] = m_sleep[1];
    v[2] = m_run[2];   v[3] = m_run[3];
    return v;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk("mode", 32'(mode), 32'(m_mode));
      chk("core_clk_en", 32'(core_clk_en), 32'(m_mode == 0));
      chk("periph_clk_en", 32'(periph_clk_en), 32'(m_clk));
      chk("analog_pd", 32'(analog_pd), 32'(exp_pd()));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_wfi();
    wfi = 1'b1; step(1); wfi = 1'b0;
  endtask

  task automatic pulse_irq(int line);
    irq_pend[line] = 1'b1; step(1); irq_pend = '0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    step(3);
    cur_req = "R9";
    chk("reset mode", 32'(mode), 32'd0);
    chk("reset analog_pd", 32'(analog_pd), 32'hF0);
    chk("reset periph", 32'(periph_clk_en), 32'h01);
    rst_n = 1'b1;
    step(2);
    cur_req = "R10";
    wr(2'd0, 8'h38); wr(2'd1, 8'h02); wr(2'd2, 8'hA5); wr(2'd3, 8'hFF);
    step(2);
    cur_req = "R1"; pulse_wfi();
    cur_req = "R6"; step(4);
    cur_req = "R5"; pulse_irq(3); step(3);
    cur_req = "R2"; deep_sel = 1'b1; pulse_wfi(); deep_sel = 1'b0;
    cur_req = "R7"; step(4);
    cur_req = "R8"; pulse_irq(6); step(4);
    cur_req = "R7"; wr(2'd0, 8'h30); wr(2'd1, 8'h01);
    deep_sel = 1'b1; pulse_wfi(); deep_sel = 1'b0; step(3);
    cur_req = "R8"; pulse_irq(0); step(4);
    cur_req = "R3"; dpd_en = 1'b1; deep_sel = 1'b1; pulse_wfi(); step(3);
    dpd_en = 1'b0; deep_sel = 1'b0;
    cur_req = "R4"; irq_pend[1] = 1'b1; step(3); pulse_wfi(); step(2);
    irq_pend = '0; step(3);
    cur_req = "R9"; pulse_wfi(); step(2);
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(3);
    finish_run();
  end
endmodule